// File: doc/BRIEF.md
# SMBus Block Transfer Buffer and Byte Handshake

This block sits between the byte-wide register port of an SMBus host and its serial engine. It carries the data phase of block transfers in both directions. Software picks one of two ways of moving the bytes. In buffer mode, software fills a 32-entry buffer before a write, or empties it after a read, through one data port. Each access to that port steps an internal index. In byte mode, the block moves one byte at a time through a holding register, and a byte-done status flag paces it. The block stalls the serial engine until software acknowledges that flag.

The block length travels through the length register. Software writes it before a block write. The length byte that arrives first in an SMBus block read lands in the same register. For an I2C-style block read, the address byte goes out with its direction bit forced low, and the command byte is taken from the auxiliary data register. The final read byte is answered with NACK. In buffer mode the byte count decides which byte is last. In byte mode software decides, by writing a last-byte command code.

Sequencer states, in the order a transfer walks them. IDLE waits for a start. TXLEN offers the length byte. TXDAT offers data bytes. RXLEN takes the length byte. RXDAT takes data bytes. HSHAKE waits for the byte-done acknowledge. STOP requests and waits for the bus stop. The transitions are:
- IDLE to TXLEN, TXDAT, RXLEN or RXDAT on a start, chosen by direction and kind.
- TXLEN to TXDAT when the engine accepts the length byte.
- TXDAT to HSHAKE in byte mode after each byte. In buffer mode, TXDAT goes to STOP after the last byte.
- RXLEN to RXDAT on a valid length, or to STOP on a bad length.
- RXDAT to HSHAKE in byte mode. In buffer mode, RXDAT goes to STOP after the NACKed byte.
- HSHAKE back to TXDAT or RXDAT, or on to STOP once the final byte is done.
- STOP to IDLE on the engine's stop-done.

Top module: `smbb_host`

## Requirements
- R1: Register 7 (aux) keeps two bits. Bit 1 selects buffer mode and bit 0 drives `crc_en`. Both reset to 0 and read back as written.
- R2: Reading register 1 (control) returns the index of the block buffer to entry 0.
- R3: In buffer mode each read or write of register 6 (block port) touches the buffer entry at the index and then steps the index by one. The index wraps from entry 31 to entry 0.
- R4: A block write of length L (register 4) offers the length byte first and then L data bytes. An I2C kind offers only the L data bytes. In buffer mode the data bytes come from buffer entries 0 to L-1.
- R5: In an SMBus block read, the first received byte is written into register 4. Data bytes fill buffer entries 0 upward in buffer mode. `eng_rx_nack` is high exactly while the L-th data byte is being offered.
- R6: In byte mode, status bit 7 rises after every data byte. No further byte is offered or accepted until software writes 1 to bit 7. Register 6 then reaches a single holding register, and reading it does not step any index.
- R7: In byte mode `eng_rx_nack` follows bit 3 of the control kind field. That bit is set by the last-byte codes 0x34 (block) and 0x38 (I2C block).
- R8: A received length byte of 0 or above 32 sets status bit 2. It leaves register 4 unchanged, takes no data byte, goes to STOP, and leaves status bit 1 clear.
- R9: Status bit 1 (done) rises only on `eng_stop_done` of a transfer without error. Bit 0 (busy) is high from start until stop-done. Bits 7, 2 and 1 are cleared by writing 1.
- R10: An I2C block read presents the address byte with bit 0 cleared and takes `eng_cmd_byte` from register 5. Other kinds present registers 2 and 3 unchanged.
- R11: A control write stores bits 5:2 as the kind field and starts a transfer only when bit 6 is set. Kind bit 1 selects the I2C form. The codes are 0x14 block, 0x18 I2C block, and 0x34/0x38 for their last-byte variants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on control and block port) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| crc_en | output | 1 | Hardware CRC enable to the serial engine |
| eng_start | output | 1 | Start pulse to the serial engine |
| eng_addr_byte | output | 8 | Address byte to send |
| eng_cmd_byte | output | 8 | Command byte to send |
| eng_rd | output | 1 | Data phase direction (1 = read) |
| eng_i2c | output | 1 | I2C form: no length byte on the wire |
| eng_tx_valid | output | 1 | Byte offered to the engine |
| eng_tx_data | output | 8 | Offered byte |
| eng_tx_ready | input | 1 | Engine takes the offered byte |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_ready | output | 1 | Block can take a received byte |
| eng_rx_nack | output | 1 | Answer the coming byte with NACK |
| eng_stop | output | 1 | Request for a STOP condition |
| eng_stop_done | input | 1 | STOP completed |

## Verification
The tests run block writes of several lengths and seeds in both SMBus and I2C form, including a single byte and a full 32 bytes. These separate an off-by-one in the byte count, a missing or extra length byte, and buffer entries read out of order. Buffer-mode reads check where NACK falls and the read-back order through the index, along with its reset on a control read and its wrap after 32 accesses. Byte-mode writes and reads test the stall during the handshake and the last-byte code. Bad lengths of 0 and 33 show that an error ends the transfer without storing data or raising done.

// File: rtl/smbb_pkg.sv
package smbb_pkg;
    localparam logic [2:0] RA_STAT = 3'd0;
    localparam logic [2:0] RA_CTRL = 3'd1;
    localparam logic [2:0] RA_ADDR = 3'd2;
    localparam logic [2:0] RA_CMD  = 3'd3;
    localparam logic [2:0] RA_LEN  = 3'd4;
    localparam logic [2:0] RA_DAT1 = 3'd5;
    localparam logic [2:0] RA_BLK  = 3'd6;
    localparam logic [2:0] RA_AUX  = 3'd7;

    localparam int SB_BYTE_DONE = 7;
    localparam int SB_LEN_ERR   = 2;
    localparam int SB_DONE      = 1;
    localparam int CB_GO        = 6;
    localparam int KB_I2C       = 1;
    localparam int KB_LAST      = 3;
    localparam int AB_BUF       = 1;
    localparam int AB_CRC       = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TXLEN,
        ST_TXDAT,
        ST_RXLEN,
        ST_RXDAT,
        ST_HSHAKE,
        ST_STOP
    } seq_state_t;
endpackage

// File: rtl/smbb_buf.sv
module smbb_buf #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_wr,
    input  logic          sw_rd,
    input  logic          sw_clr,
    input  logic [DW-1:0] sw_wdata,
    output logic [DW-1:0] sw_rdata,
    input  logic          hw_we,
    input  logic [IW-1:0] hw_addr,
    input  logic [DW-1:0] hw_wdata,
    output logic [DW-1:0] hw_rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [IW-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (sw_clr) begin
            idx <= '0;
        end else if (sw_wr || sw_rd) begin
            idx <= (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (hw_we) begin
            mem[hw_addr] <= hw_wdata;
        end else if (sw_wr) begin
            mem[idx] <= sw_wdata;
        end
    end

    assign sw_rdata = mem[idx];
    assign hw_rdata = mem[hw_addr];

    // R3: a port write lands in the entry the index pointed at
    a_r3_port_store: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !hw_we) |=> (mem[$past(idx)] == $past(sw_wdata)));
endmodule

// File: rtl/smbb_seq.sv
module smbb_seq
    import smbb_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          rd_dir,
    input  logic          i2c,
    input  logic          buf_mode,
    input  logic          last_kind,
    input  logic [7:0]    len,
    input  logic          tx_ready,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          byte_ack,
    input  logic          stop_done,
    output logic          busy,
    output logic          start_pulse,
    output logic          tx_valid,
    output logic          tx_len_sel,
    output logic          use_buf,
    output logic          rx_ready,
    output logic          rx_nack,
    output logic [IW-1:0] buf_addr,
    output logic          buf_we,
    output logic          hold_we,
    output logic          len_we,
    output logic          bd_set,
    output logic          done_set,
    output logic          err_set,
    output logic          stop_req
);
    seq_state_t st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          was_last, was_last_n;
    logic          err_pend, err_pend_n;
    logic          dir_q, dir_n;
    logic          bufm_q, bufm_n;

    logic [8:0] cnt9, cnt_inc, len9;
    logic       len_bad, nack_now;

    assign cnt9     = 9'(cnt);
    assign cnt_inc  = cnt9 + 9'd1;
    assign len9     = {1'b0, len};
    assign len_bad  = (rx_data == 8'd0) || ({1'b0, rx_data} > 9'(DEPTH));
    assign nack_now = bufm_q ? (cnt_inc >= len9) : last_kind;

    always_comb begin
        st_n       = st;
        cnt_n      = cnt;
        was_last_n = was_last;
        err_pend_n = err_pend;
        dir_n      = dir_q;
        bufm_n     = bufm_q;
        unique case (st)
            ST_IDLE: begin
                if (go) begin
                    cnt_n      = '0;
                    was_last_n = 1'b0;
                    err_pend_n = 1'b0;
                    dir_n      = rd_dir;
                    bufm_n     = buf_mode;
                    if (rd_dir) st_n = i2c ? ST_RXDAT : ST_RXLEN;
                    else        st_n = i2c ? ST_TXDAT : ST_TXLEN;
                end
            end
            ST_TXLEN: begin
                if (tx_ready) st_n = ST_TXDAT;
            end
            ST_TXDAT: begin
                if (tx_ready) begin
                    cnt_n = cnt + 1'b1;
                    if (!bufm_q)              st_n = ST_HSHAKE;
                    else if (cnt_inc >= len9) st_n = ST_STOP;
                end
            end
            ST_RXLEN: begin
                if (rx_valid) begin
                    if (len_bad) begin
                        err_pend_n = 1'b1;
                        st_n       = ST_STOP;
                    end else begin
                        st_n = ST_RXDAT;
                    end
                end
            end
            ST_RXDAT: begin
                if (rx_valid) begin
                    cnt_n      = cnt + 1'b1;
                    was_last_n = nack_now;
                    if (!bufm_q)       st_n = ST_HSHAKE;
                    else if (nack_now) st_n = ST_STOP;
                end
            end
            ST_HSHAKE: begin
                if (byte_ack) begin
                    if (dir_q) st_n = was_last ? ST_STOP : ST_RXDAT;
                    else       st_n = (cnt9 >= len9) ? ST_STOP : ST_TXDAT;
                end
            end
            ST_STOP: begin
                if (stop_done) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            was_last <= 1'b0;
            err_pend <= 1'b0;
            dir_q    <= 1'b0;
            bufm_q   <= 1'b0;
        end else begin
            st       <= st_n;
            cnt      <= cnt_n;
            was_last <= was_last_n;
            err_pend <= err_pend_n;
            dir_q    <= dir_n;
            bufm_q   <= bufm_n;
        end
    end

    always_comb begin
        busy        = (st != ST_IDLE);
        start_pulse = (st == ST_IDLE) && go;
        tx_valid    = (st == ST_TXLEN) || (st == ST_TXDAT);
        tx_len_sel  = (st == ST_TXLEN);
        use_buf     = bufm_q;
        rx_ready    = (st == ST_RXLEN) || (st == ST_RXDAT);
        rx_nack     = (st == ST_RXDAT) && nack_now;
        buf_addr    = cnt[IW-1:0];
        len_we      = (st == ST_RXLEN) && rx_valid && !len_bad;
        err_set     = (st == ST_RXLEN) && rx_valid && len_bad;
        buf_we      = (st == ST_RXDAT) && rx_valid && bufm_q;
        hold_we     = (st == ST_RXDAT) && rx_valid && !bufm_q;
        bd_set      = !bufm_q && (((st == ST_TXDAT) && tx_ready) ||
                                  ((st == ST_RXDAT) && rx_valid));
        done_set    = (st == ST_STOP) && stop_done && !err_pend;
        stop_req    = (st == ST_STOP);
    end

    // R8: a bad length byte sends the sequencer straight to STOP
    a_r8_bad_len_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RXLEN && rx_valid && len_bad) |=> (st == ST_STOP && !rx_ready));

    // R4/R5: the block never offers and takes a byte at the same time
    a_r5_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && rx_ready));

    // R7: NACK is only signalled while a data byte can be taken
    a_r7_nack_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
        rx_nack |-> (rx_ready && !tx_valid));
endmodule

// File: rtl/smbb_host.sv
module smbb_host
    import smbb_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       crc_en,
    output logic       eng_start,
    output logic [7:0] eng_addr_byte,
    output logic [7:0] eng_cmd_byte,
    output logic       eng_rd,
    output logic       eng_i2c,
    output logic       eng_tx_valid,
    output logic [7:0] eng_tx_data,
    input  logic       eng_tx_ready,
    input  logic       eng_rx_valid,
    input  logic [7:0] eng_rx_data,
    output logic       eng_rx_ready,
    output logic       eng_rx_nack,
    output logic       eng_stop,
    input  logic       eng_stop_done
);
    logic [3:0] kind_q;
    logic [7:0] addr_q, cmd_q, len_q, dat1_q, hold_q;
    logic       aux_buf, aux_crc;
    logic       bd_q, dn_q, er_q;

    logic stat_wr, ctrl_wr, blk_wr, blk_rd, ctrl_rd;
    logic go, byte_ack;
    logic [3:0] kind_in;

    logic          busy, tx_len_sel, use_buf, buf_we, hold_we, len_we;
    logic          bd_set, done_set, err_set;
    logic [IW-1:0] buf_addr;
    logic [7:0]    sw_rdata, hw_rdata;

    assign stat_wr  = reg_wr && (reg_addr == RA_STAT);
    assign ctrl_wr  = reg_wr && (reg_addr == RA_CTRL);
    assign blk_wr   = reg_wr && (reg_addr == RA_BLK);
    assign blk_rd   = reg_rd && (reg_addr == RA_BLK);
    assign ctrl_rd  = reg_rd && (reg_addr == RA_CTRL);
    assign go       = ctrl_wr && reg_wdata[CB_GO];
    assign kind_in  = ctrl_wr ? reg_wdata[5:2] : kind_q;
    assign byte_ack = stat_wr && reg_wdata[SB_BYTE_DONE] && bd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= '0;
            addr_q  <= '0;
            cmd_q   <= '0;
            len_q   <= '0;
            dat1_q  <= '0;
            hold_q  <= '0;
            aux_buf <= 1'b0;
            aux_crc <= 1'b0;
        end else begin
            if (ctrl_wr) kind_q <= reg_wdata[5:2];
            if (reg_wr && reg_addr == RA_ADDR) addr_q <= reg_wdata;
            if (reg_wr && reg_addr == RA_CMD)  cmd_q  <= reg_wdata;
            if (reg_wr && reg_addr == RA_DAT1) dat1_q <= reg_wdata;
            if (reg_wr && reg_addr == RA_AUX) begin
                aux_buf <= reg_wdata[AB_BUF];
                aux_crc <= reg_wdata[AB_CRC];
            end
            if (len_we)                          len_q <= eng_rx_data;
            else if (reg_wr && reg_addr == RA_LEN) len_q <= reg_wdata;
            if (hold_we)                  hold_q <= eng_rx_data;
            else if (blk_wr && !aux_buf)  hold_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bd_q <= 1'b0;
            dn_q <= 1'b0;
            er_q <= 1'b0;
        end else begin
            if (bd_set)                                  bd_q <= 1'b1;
            else if (stat_wr && reg_wdata[SB_BYTE_DONE]) bd_q <= 1'b0;
            if (done_set)                                dn_q <= 1'b1;
            else if (stat_wr && reg_wdata[SB_DONE])      dn_q <= 1'b0;
            if (err_set)                                 er_q <= 1'b1;
            else if (stat_wr && reg_wdata[SB_LEN_ERR])   er_q <= 1'b0;
        end
    end

    smbb_buf #(.DEPTH(DEPTH), .DW(8)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr    (blk_wr && aux_buf),
        .sw_rd    (blk_rd && aux_buf),
        .sw_clr   (ctrl_rd),
        .sw_wdata (reg_wdata),
        .sw_rdata (sw_rdata),
        .hw_we    (buf_we),
        .hw_addr  (buf_addr),
        .hw_wdata (eng_rx_data),
        .hw_rdata (hw_rdata)
    );

    smbb_seq #(.DEPTH(DEPTH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .rd_dir      (addr_q[0]),
        .i2c         (kind_in[KB_I2C]),
        .buf_mode    (aux_buf),
        .last_kind   (kind_q[KB_LAST]),
        .len         (len_q),
        .tx_ready    (eng_tx_ready),
        .rx_valid    (eng_rx_valid),
        .rx_data     (eng_rx_data),
        .byte_ack    (byte_ack),
        .stop_done   (eng_stop_done),
        .busy        (busy),
        .start_pulse (eng_start),
        .tx_valid    (eng_tx_valid),
        .tx_len_sel  (tx_len_sel),
        .use_buf     (use_buf),
        .rx_ready    (eng_rx_ready),
        .rx_nack     (eng_rx_nack),
        .buf_addr    (buf_addr),
        .buf_we      (buf_we),
        .hold_we     (hold_we),
        .len_we      (len_we),
        .bd_set      (bd_set),
        .done_set    (done_set),
        .err_set     (err_set),
        .stop_req    (eng_stop)
    );

    assign crc_en        = aux_crc;
    assign eng_i2c       = kind_q[KB_I2C];
    assign eng_rd        = addr_q[0];
    assign eng_addr_byte = (kind_q[KB_I2C] && addr_q[0]) ? {addr_q[7:1], 1'b0} : addr_q;
    assign eng_cmd_byte  = (kind_q[KB_I2C] && addr_q[0]) ? dat1_q : cmd_q;
    assign eng_tx_data   = tx_len_sel ? len_q : (use_buf ? hw_rdata : hold_q);

    always_comb begin
        case (reg_addr)
            RA_STAT: reg_rdata = {bd_q, 4'b0000, er_q, dn_q, busy};
            RA_CTRL: reg_rdata = {2'b00, kind_q, 2'b00};
            RA_ADDR: reg_rdata = addr_q;
            RA_CMD:  reg_rdata = cmd_q;
            RA_LEN:  reg_rdata = len_q;
            RA_DAT1: reg_rdata = dat1_q;
            RA_BLK:  reg_rdata = aux_buf ? sw_rdata : hold_q;
            default: reg_rdata = {6'b000000, aux_buf, aux_crc};
        endcase
    end

    // R9: done only rises on the cycle the engine reports its STOP
    a_r9_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_q) |-> $past(eng_stop_done));

    // R6: a pending byte-done flag holds the serial side still
    a_r6_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (bd_q && !byte_ack) |=> (!eng_tx_valid && !eng_rx_ready));
endmodule

// File: tb/tb_smbb_host.sv
module tb_smbb_host;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       crc_en, eng_start, eng_rd, eng_i2c;
    logic [7:0] eng_addr_byte, eng_cmd_byte, eng_tx_data;
    logic       eng_tx_valid, eng_rx_ready, eng_rx_nack, eng_stop;
    logic       eng_tx_ready = 1'b0, eng_rx_valid = 1'b0, eng_stop_done = 1'b0;
    logic [7:0] eng_rx_data = '0;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    smbb_host dut (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .crc_en(crc_en), .eng_start(eng_start),
        .eng_addr_byte(eng_addr_byte), .eng_cmd_byte(eng_cmd_byte),
        .eng_rd(eng_rd), .eng_i2c(eng_i2c),
        .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_ready(eng_tx_ready),
        .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready),
        .eng_rx_nack(eng_rx_nack), .eng_stop(eng_stop), .eng_stop_done(eng_stop_done)
    );

    // {i2c kind, length, seed}; data byte i = seed + 3*i
    localparam logic [16:0] WTAB [5] = '{
        {1'b0, 8'd1,  8'h10},
        {1'b1, 8'd2,  8'h20},
        {1'b0, 8'd5,  8'h30},
        {1'b0, 8'd32, 8'h40},
        {1'b1, 8'd7,  8'h90}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic take_tx(input string req, input logic [7:0] exp);
        while (!eng_tx_valid) @(negedge clk);
        chk(req, eng_tx_data, exp);
        eng_tx_ready = 1'b1;
        @(negedge clk);
        eng_tx_ready = 1'b0;
    endtask

    task automatic give_rx(input string req, input logic [7:0] d, input logic nack_exp);
        while (!eng_rx_ready) @(negedge clk);
        chk(req, eng_rx_nack, nack_exp);
        eng_rx_valid = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_valid = 1'b0;
    endtask

    task automatic finish_stop();
        while (!eng_stop) @(negedge clk);
        eng_stop_done = 1'b1;
        @(negedge clk);
        eng_stop_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R1, R9)
        rreg(3'd0, v); chk("R9 reset status", v, 8'h00);
        rreg(3'd7, v); chk("R1 reset aux", v, 8'h00);
        chk("R1 reset crc_en", crc_en, 1'b0);

        // R1 aux bits
        wreg(3'd7, 8'h03);
        rreg(3'd7, v); chk("R1 aux readback", v, 8'h03);
        chk("R1 crc_en", crc_en, 1'b1);
        wreg(3'd7, 8'h02);

        // R11 kind field without start
        wreg(3'd1, 8'h38);
        rreg(3'd1, v); chk("R11 kind readback", v, 8'h38);
        rreg(3'd0, v); chk("R11 no start without go", v, 8'h00);

        // R2 index reset on control read
        rreg(3'd1, v);
        for (int i = 0; i < 3; i++) wreg(3'd6, 8'hB0 + 8'(i));
        rreg(3'd1, v);
        rreg(3'd6, v); chk("R2 index back to 0", v, 8'hB0);
        rreg(3'd6, v); chk("R3 index steps", v, 8'hB1);

        // R3 wrap after 32 accesses
        rreg(3'd1, v);
        for (int i = 0; i < 33; i++) wreg(3'd6, 8'hA0 + 8'(i));
        rreg(3'd1, v);
        rreg(3'd6, v); chk("R3 wrap overwrote entry 0", v, 8'hC0);
        rreg(3'd6, v); chk("R3 entry 1 after wrap", v, 8'hA1);

        // R4 block writes from the table
        for (int r = 0; r < 5; r++) begin
            logic       wi2c;
            logic [7:0] wlen, wseed;
            {wi2c, wlen, wseed} = WTAB[r];
            wreg(3'd7, 8'h02);
            rreg(3'd1, v);
            wreg(3'd4, wlen);
            for (int i = 0; i < int'(wlen); i++) wreg(3'd6, wseed + 8'(3 * i));
            wreg(3'd2, 8'hA0);
            wreg(3'd1, wi2c ? 8'h58 : 8'h54);
            chk("R10 write address byte", eng_addr_byte, 8'hA0);
            chk("R11 i2c kind", eng_i2c, wi2c);
            if (!wi2c) take_tx("R4 length byte", wlen);
            for (int i = 0; i < int'(wlen); i++) take_tx("R4 data byte", wseed + 8'(3 * i));
            finish_stop();
            rreg(3'd0, v); chk("R9 done after write", v, 8'h02);
            wreg(3'd0, 8'h02);
            rreg(3'd0, v); chk("R9 done cleared", v, 8'h00);
        end

        // R5 SMBus block read in buffer mode
        wreg(3'd7, 8'h02);
        wreg(3'd3, 8'h11);
        wreg(3'd5, 8'h5C);
        wreg(3'd2, 8'hA1);
        wreg(3'd1, 8'h54);
        chk("R10 smbus read address", eng_addr_byte, 8'hA1);
        chk("R10 smbus read command", eng_cmd_byte, 8'h11);
        rreg(3'd0, v); chk("R9 busy during read", v, 8'h01);
        give_rx("R5 length byte no nack", 8'd3, 1'b0);
        give_rx("R5 byte 1 no nack", 8'h61, 1'b0);
        give_rx("R5 byte 2 no nack", 8'h62, 1'b0);
        give_rx("R5 last byte nack", 8'h63, 1'b1);
        finish_stop();
        rreg(3'd0, v); chk("R9 done after read", v, 8'h02);
        wreg(3'd0, 8'h02);
        rreg(3'd4, v); chk("R5 length in data0", v, 8'd3);
        rreg(3'd1, v);
        rreg(3'd6, v); chk("R5 entry 0", v, 8'h61);
        rreg(3'd6, v); chk("R5 entry 1", v, 8'h62);
        rreg(3'd6, v); chk("R5 entry 2", v, 8'h63);

        // R8 bad lengths: above 32, then zero
        for (int k = 0; k < 2; k++) begin
            wreg(3'd1, 8'h54);
            give_rx("R8 bad length offered", (k == 0) ? 8'd33 : 8'd0, 1'b0);
            chk("R8 no further byte taken", eng_rx_ready, 1'b0);
            chk("R8 stop requested", eng_stop, 1'b1);
            finish_stop();
            rreg(3'd0, v); chk("R8 error set, done clear", v, 8'h04);
            rreg(3'd4, v); chk("R8 data0 unchanged", v, 8'd3);
            rreg(3'd1, v);
            rreg(3'd6, v); chk("R8 buffer unchanged", v, 8'h61);
            wreg(3'd0, 8'h04);
        end

        // R10 I2C block read
        wreg(3'd4, 8'd2);
        wreg(3'd1, 8'h58);
        chk("R10 i2c read address bit0 cleared", eng_addr_byte, 8'hA0);
        chk("R10 i2c read command from data1", eng_cmd_byte, 8'h5C);
        chk("R10 read direction", eng_rd, 1'b1);
        give_rx("R5 i2c byte 1", 8'h71, 1'b0);
        give_rx("R5 i2c last nack", 8'h72, 1'b1);
        finish_stop();
        wreg(3'd0, 8'h02);
        rreg(3'd1, v);
        rreg(3'd6, v); chk("R10 i2c entry 0", v, 8'h71);
        rreg(3'd6, v); chk("R10 i2c entry 1", v, 8'h72);

        // R6 byte-mode write
        wreg(3'd7, 8'h00);
        wreg(3'd4, 8'd2);
        wreg(3'd6, 8'h11);
        wreg(3'd2, 8'hA0);
        wreg(3'd1, 8'h54);
        take_tx("R6 length byte", 8'd2);
        take_tx("R6 first byte from hold", 8'h11);
        rreg(3'd0, v); chk("R6 byte done raised", v, 8'h81);
        repeat (3) @(negedge clk);
        chk("R6 stall while pending", eng_tx_valid, 1'b0);
        wreg(3'd6, 8'h22);
        wreg(3'd0, 8'h80);
        take_tx("R6 second byte", 8'h22);
        rreg(3'd0, v); chk("R6 byte done after last", v, 8'h81);
        wreg(3'd0, 8'h80);
        finish_stop();
        rreg(3'd0, v); chk("R9 byte-mode write done", v, 8'h02);
        wreg(3'd0, 8'h02);

        // R7 byte-mode read with last-byte code
        wreg(3'd2, 8'hA1);
        wreg(3'd1, 8'h54);
        give_rx("R7 length byte", 8'd2, 1'b0);
        give_rx("R7 first byte no nack", 8'h33, 1'b0);
        repeat (2) @(negedge clk);
        chk("R6 rx stall while pending", eng_rx_ready, 1'b0);
        rreg(3'd6, v); chk("R6 hold byte 1", v, 8'h33);
        rreg(3'd6, v); chk("R6 hold not stepped", v, 8'h33);
        wreg(3'd1, 8'h34);
        wreg(3'd0, 8'h80);
        give_rx("R7 last code gives nack", 8'h44, 1'b1);
        rreg(3'd0, v); chk("R6 byte done on last", v, 8'h81);
        rreg(3'd6, v); chk("R6 hold byte 2", v, 8'h44);
        wreg(3'd0, 8'h80);
        finish_stop();
        rreg(3'd0, v); chk("R9 byte-mode read done", v, 8'h02);
        rreg(3'd4, v); chk("R5 byte-mode length", v, 8'd2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule